// File: doc/BRIEF.md
# Data-Processing ALU with Flag Generation

This block is the combinational arithmetic and logic unit of a processor core's execute stage. It takes a first operand, a second operand that has already been through the shifter, the current carry and overflow flags, and the carry produced by the shifter. A 4-bit opcode selects one of sixteen data-processing operations. These fall into three groups: bitwise logic, two's-complement addition and subtraction (each with or without the carry flag, and with the operands swapped for reverse subtraction), and a compare/test group that only changes the flags.

The block produces the 32-bit result and a register write-enable. It also produces the new negative, zero, carry and overflow flags together with one enable that says whether the flag register should take them. Compare/test opcodes always update the flags and never write a register. Every other opcode writes a register and updates the flags only when the set-flags bit is high.

Top module: `dp_alu`

## Requirements
- R1: Logic opcodes give AND=0000 op1&op2, EOR=0001 op1^op2, ORR=1100 op1|op2, BIC=1110 op1&~op2.
- R2: MOV=1101 returns op2, and MVN=1111 returns ~op2, so op2=0 gives 32'hFFFF_FFFF.
- R3: ADD=0100 returns op1+op2, and ADC=0101 returns op1+op2+carryIn, both modulo 2^32.
- R4: SUB=0010 returns op1-op2, and RSB=0011 returns op2-op1.
- R5: SBC=0110 returns op1-op2-(1-carryIn), and RSC=0111 returns op2-op1-(1-carryIn).
- R6: Opcodes 1000..1011 are TST (AND), TEQ (XOR), CMP (op1-op2) and CMN (op1+op2). For these, regWe=0 and flagWe=1 whatever setFlags is, and result still carries the computed value.
- R7: For every other opcode, regWe=1 and flagWe equals setFlags.
- R8: newN equals result bit 31, and newZ is 1 exactly when result is zero.
- R9: For arithmetic opcodes (0010..0111, 1010, 1011), newC is the carry out of bit 31 of the adder. For subtractive forms this makes 1 mean no borrow. newV is set on signed two's-complement overflow.
- R10: For logic opcodes (0000, 0001, 1000, 1001, 1100..1111), newC equals shiftCarry and newV equals ovIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op1 | input | 32 | First operand |
| op2 | input | 32 | Second operand, already shifted |
| carryIn | input | 1 | Current carry flag |
| ovIn | input | 1 | Current overflow flag |
| shiftCarry | input | 1 | Carry out of the shifter |
| opcode | input | 4 | Operation select |
| setFlags | input | 1 | Request flag update for non-compare opcodes |
| result | output | 32 | Operation result |
| regWe | output | 1 | Destination register write-enable |
| newN | output | 1 | Negative flag value |
| newZ | output | 1 | Zero flag value |
| newC | output | 1 | Carry flag value |
| newV | output | 1 | Overflow flag value |
| flagWe | output | 1 | Flag register write-enable |

## Verification
The assertions take for granted that every input is driven to a known 0 or 1, since opcode classification and the zero test mean nothing on unknown bits. They also assume the inputs have settled before the outputs are sampled. The bench changes inputs only on the falling clock edge and compares on the rising edge, half a period later. It drives only fully known vectors: each of the sixteen opcodes is swept over fixed corner operands (zero, all ones, the signed extremes) with both carry values and both setFlags values, and then over seeded pseudo-random operands.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'b0000, OP_EOR = 4'b0001, OP_SUB = 4'b0010, OP_RSB = 4'b0011,
    OP_ADD = 4'b0100, OP_ADC = 4'b0101, OP_SBC = 4'b0110, OP_RSC = 4'b0111,
    OP_TST = 4'b1000, OP_TEQ = 4'b1001, OP_CMP = 4'b1010, OP_CMN = 4'b1011,
    OP_ORR = 4'b1100, OP_MOV = 4'b1101, OP_BIC = 4'b1110, OP_MVN = 4'b1111
  } aluOp_t;

  typedef enum logic [2:0] {
    LG_AND, LG_XOR, LG_OR, LG_PASSB, LG_ANDNB, LG_NOTB
  } logicSel_t;

  typedef enum logic [1:0] {
    CIN_ZERO, CIN_ONE, CIN_FLAG
  } cinSel_t;

  typedef struct packed {
    logic      isArith;
    logic      invA;
    logic      invB;
    cinSel_t   cinSel;
    logicSel_t logicSel;
    logic      wrEn;
    logic      forceFlags;
  } strobes_t;

endpackage

// File: rtl/dp_alu_ctrl.sv
module dp_alu_ctrl
  import dp_alu_pkg::*;
(
  input  logic [3:0] opcode,
  output strobes_t   strobes
);

  always_comb begin
    strobes = '{isArith: 1'b0, invA: 1'b0, invB: 1'b0, cinSel: CIN_ZERO,
                logicSel: LG_AND, wrEn: 1'b1, forceFlags: 1'b0};
    unique case (aluOp_t'(opcode))
      OP_AND: strobes.logicSel = LG_AND;
      OP_EOR: strobes.logicSel = LG_XOR;
      OP_ORR: strobes.logicSel = LG_OR;
      OP_MOV: strobes.logicSel = LG_PASSB;
      OP_BIC: strobes.logicSel = LG_ANDNB;
      OP_MVN: strobes.logicSel = LG_NOTB;
      OP_SUB: begin
        strobes.isArith = 1'b1; strobes.invB = 1'b1; strobes.cinSel = CIN_ONE;
      end
      OP_RSB: begin
        strobes.isArith = 1'b1; strobes.invA = 1'b1; strobes.cinSel = CIN_ONE;
      end
      OP_ADD: strobes.isArith = 1'b1;
      OP_ADC: begin
        strobes.isArith = 1'b1; strobes.cinSel = CIN_FLAG;
      end
      OP_SBC: begin
        strobes.isArith = 1'b1; strobes.invB = 1'b1; strobes.cinSel = CIN_FLAG;
      end
      OP_RSC: begin
        strobes.isArith = 1'b1; strobes.invA = 1'b1; strobes.cinSel = CIN_FLAG;
      end
      OP_TST: begin
        strobes.logicSel = LG_AND; strobes.wrEn = 1'b0; strobes.forceFlags = 1'b1;
      end
      OP_TEQ: begin
        strobes.logicSel = LG_XOR; strobes.wrEn = 1'b0; strobes.forceFlags = 1'b1;
      end
      OP_CMP: begin
        strobes.isArith = 1'b1; strobes.invB = 1'b1; strobes.cinSel = CIN_ONE;
        strobes.wrEn = 1'b0; strobes.forceFlags = 1'b1;
      end
      OP_CMN: begin
        strobes.isArith = 1'b1; strobes.wrEn = 1'b0; strobes.forceFlags = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dp_alu_path.sv
module dp_alu_path
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op1,
  input  logic [WIDTH-1:0] op2,
  input  logic             carryIn,
  input  logic             ovIn,
  input  logic             shiftCarry,
  input  logic             setFlags,
  input  strobes_t         strobes,
  output logic [WIDTH-1:0] result,
  output logic             regWe,
  output logic             newN,
  output logic             newZ,
  output logic             newC,
  output logic             newV,
  output logic             flagWe
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] addA, addB, logicOut;
  logic [WIDTH:0]   sumWide;
  logic             addCin, addOvf;

  // adder leg: operand inversion plus a selectable carry-in
  always_comb begin
    addA = strobes.invA ? ~op1 : op1;
    addB = strobes.invB ? ~op2 : op2;
    unique case (strobes.cinSel)
      CIN_ONE:  addCin = 1'b1;
      CIN_FLAG: addCin = carryIn;
      default:  addCin = 1'b0;
    endcase
    sumWide = {1'b0, addA} + {1'b0, addB} + {{WIDTH{1'b0}}, addCin};
    addOvf  = (addA[MSB] == addB[MSB]) && (sumWide[MSB] != addA[MSB]);
  end

  // logic leg
  always_comb begin
    unique case (strobes.logicSel)
      LG_XOR:   logicOut = op1 ^ op2;
      LG_OR:    logicOut = op1 | op2;
      LG_PASSB: logicOut = op2;
      LG_ANDNB: logicOut = op1 & ~op2;
      LG_NOTB:  logicOut = ~op2;
      default:  logicOut = op1 & op2;
    endcase
  end

  always_comb begin
    result = strobes.isArith ? sumWide[MSB:0] : logicOut;
    newN   = result[MSB];
    newZ   = (result == '0);
    newC   = strobes.isArith ? sumWide[WIDTH] : shiftCarry;
    newV   = strobes.isArith ? addOvf : ovIn;
    regWe  = strobes.wrEn;
    flagWe = strobes.forceFlags | setFlags;
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op1,
  input  logic [WIDTH-1:0] op2,
  input  logic             carryIn,
  input  logic             ovIn,
  input  logic             shiftCarry,
  input  logic [3:0]       opcode,
  input  logic             setFlags,
  output logic [WIDTH-1:0] result,
  output logic             regWe,
  output logic             newN,
  output logic             newZ,
  output logic             newC,
  output logic             newV,
  output logic             flagWe
);

  strobes_t strobes;

  dp_alu_ctrl u_ctrl (
    .opcode  (opcode),
    .strobes (strobes)
  );

  dp_alu_path #(.WIDTH(WIDTH)) u_path (
    .op1        (op1),
    .op2        (op2),
    .carryIn    (carryIn),
    .ovIn       (ovIn),
    .shiftCarry (shiftCarry),
    .setFlags   (setFlags),
    .strobes    (strobes),
    .result     (result),
    .regWe      (regWe),
    .newN       (newN),
    .newZ       (newZ),
    .newC       (newC),
    .newV       (newV),
    .flagWe     (flagWe)
  );

endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] op1,
  input logic [WIDTH-1:0] op2,
  input logic             ovIn,
  input logic             shiftCarry,
  input logic [3:0]       opcode,
  input logic             setFlags,
  input logic [WIDTH-1:0] result,
  input logic             regWe,
  input logic             newN,
  input logic             newZ,
  input logic             newC,
  input logic             newV,
  input logic             flagWe
);

  logic isCompare, isLogic;
  assign isCompare = (opcode[3:2] == 2'b10);
  assign isLogic   = (opcode[3:1] == 3'b000) || (opcode[3:1] == 3'b100) ||
                     (opcode[3:2] == 2'b11);

  always_comb begin
    if (!$isunknown({opcode, setFlags, op1, op2, ovIn, shiftCarry})) begin
      AST_CMP_NO_WRITE: assert (regWe == !isCompare) else $error("regWe wrong"); // R6
      AST_FLAG_ENABLE: assert (flagWe == (isCompare || setFlags)) else $error("flagWe wrong"); // R7
      AST_N_IS_MSB: assert (newN == result[WIDTH-1]) else $error("N wrong"); // R8
      AST_Z_IS_ZERO: assert (newZ == (result == '0)) else $error("Z wrong"); // R8
      AST_LOGIC_CARRY: assert (!isLogic || newC == shiftCarry) else $error("C wrong"); // R10
      AST_LOGIC_KEEP_V: assert (!isLogic || newV == ovIn) else $error("V wrong"); // R10
      AST_MVN_INVERT: assert (opcode != 4'b1111 || result == ~op2) else $error("MVN wrong"); // R2
    end
  end

endmodule

bind dp_alu dp_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .op1(op1), .op2(op2), .ovIn(ovIn), .shiftCarry(shiftCarry),
  .opcode(opcode), .setFlags(setFlags), .result(result), .regWe(regWe),
  .newN(newN), .newZ(newZ), .newC(newC), .newV(newV), .flagWe(flagWe)
);

// File: tb/sim_dp_alu.sv
module sim_dp_alu;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  typedef struct {
    logic [3:0]   op;
    logic [W-1:0] res;
    logic         we, n, z, c, v, fwe;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] op1 = '0, op2 = '0;
  logic carryIn = 1'b0, ovIn = 1'b0, shiftCarry = 1'b0, setFlags = 1'b0;
  logic [3:0] opcode = 4'b0000;
  logic [W-1:0] result;
  logic regWe, newN, newZ, newC, newV, flagWe;

  int total = 0;
  int bad = 0;
  expItem_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_alu #(.WIDTH(W)) u0 (
    .op1(op1), .op2(op2), .carryIn(carryIn), .ovIn(ovIn),
    .shiftCarry(shiftCarry), .opcode(opcode), .setFlags(setFlags),
    .result(result), .regWe(regWe), .newN(newN), .newZ(newZ),
    .newC(newC), .newV(newV), .flagWe(flagWe)
  );

  function automatic string resTag(input logic [3:0] op);
    case (op)
      4'b0000, 4'b0001, 4'b1100, 4'b1110: return "R1";
      4'b1101, 4'b1111:                   return "R2";
      4'b0100, 4'b0101:                   return "R3";
      4'b0010, 4'b0011:                   return "R4";
      4'b0110, 4'b0111:                   return "R5";
      default:                            return "R6";
    endcase
  endfunction

  function automatic bit isArithOp(input logic [3:0] op);
    return (op >= 4'b0010 && op <= 4'b0111) || op == 4'b1010 || op == 4'b1011;
  endfunction

  // reference model written from the requirement text
  function automatic expItem_t model(input logic [3:0] op, input logic [W-1:0] a,
                                     input logic [W-1:0] b, input logic c,
                                     input logic v, input logic sc, input logic s);
    expItem_t e;
    longint ua = longint'(a), ub = longint'(b);
    longint sa = longint'($signed(a)), sb = longint'($signed(b));
    longint uRes = 0, sRes = 0;
    longint nb = c ? 0 : 1;
    bit cmp = (op[3:2] == 2'b10);
    e.op = op;
    case (op)
      4'b0000, 4'b1000: e.res = a & b;
      4'b0001, 4'b1001: e.res = a ^ b;
      4'b1100: e.res = a | b;
      4'b1101: e.res = b;
      4'b1110: e.res = a & ~b;
      4'b1111: e.res = ~b;
      default: e.res = '0;
    endcase
    if (isArithOp(op)) begin
      case (op)
        4'b0100, 4'b1011: begin uRes = ua + ub; sRes = sa + sb; end
        4'b0101: begin uRes = ua + ub + longint'(c); sRes = sa + sb + longint'(c); end
        4'b0010, 4'b1010: begin uRes = ua - ub; sRes = sa - sb; end
        4'b0011: begin uRes = ub - ua; sRes = sb - sa; end
        4'b0110: begin uRes = ua - ub - nb; sRes = sa - sb - nb; end
        default: begin uRes = ub - ua - nb; sRes = sb - sa - nb; end
      endcase
      e.res = uRes[W-1:0];
      // R9: additive carry is overflow past 2^32; subtractive carry means no borrow
      if (op == 4'b0100 || op == 4'b0101 || op == 4'b1011) e.c = (uRes > 64'hFFFF_FFFF);
      else e.c = (uRes >= 0);
      e.v = (sRes > 64'sd2147483647) || (sRes < -64'sd2147483648);
    end else begin
      e.c = sc; // R10
      e.v = v;
    end
    e.n = e.res[W-1];
    e.z = (e.res == '0);
    e.we = !cmp;
    e.fwe = cmp || s;
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic c, input logic v, input logic sc, input logic s);
    @(negedge clk);
    opcode = op; op1 = a; op2 = b; carryIn = c; ovIn = v; shiftCarry = sc; setFlags = s;
    q.push_back(model(op, a, b, c, v, sc, s));
  endtask

  // monitor: pops one expected item per rising edge
  always @(posedge clk) begin
    if (rstN && q.size() > 0) begin
      expItem_t e;
      string ft;
      e = q.pop_front();
      ft = isArithOp(e.op) ? "R9" : "R10";
      chk(result == e.res, resTag(e.op), "result", result, e.res);
      chk(regWe == e.we, (e.op[3:2] == 2'b10) ? "R6" : "R7", "regWe", W'(regWe), W'(e.we));
      chk(flagWe == e.fwe, (e.op[3:2] == 2'b10) ? "R6" : "R7", "flagWe", W'(flagWe), W'(e.fwe));
      chk(newN == e.n, "R8", "N", W'(newN), W'(e.n));
      chk(newZ == e.z, "R8", "Z", W'(newZ), W'(e.z));
      chk(newC == e.c, ft, "C", W'(newC), W'(e.c));
      chk(newV == e.v, ft, "V", W'(newV), W'(e.v));
    end
  end

  initial begin
    logic [W-1:0] corners [6];
    corners[0] = 32'h0000_0000; corners[1] = 32'hFFFF_FFFF;
    corners[2] = 32'h7FFF_FFFF; corners[3] = 32'h8000_0000;
    corners[4] = 32'h0000_0001; corners[5] = 32'h1234_5678;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // idle state after reset: AND of zeros
    drive(4'b0000, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    // named corners
    drive(4'b1111, '0, '0, 1'b0, 1'b1, 1'b1, 1'b1);               // R2 MVN 0 -> all ones
    drive(4'b0100, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b0, 1'b0, 1'b1); // R9 signed overflow
    drive(4'b1010, 32'h5, 32'h5, 1'b0, 1'b0, 1'b0, 1'b0);         // R6 CMP equal, no borrow
    drive(4'b1010, 32'h3, 32'h5, 1'b1, 1'b0, 1'b0, 1'b0);         // R9 borrow -> C=0
    drive(4'b0110, 32'h10, 32'h3, 1'b0, 1'b0, 1'b0, 1'b1);        // R5 SBC with C=0
    drive(4'b0111, 32'h3, 32'h10, 1'b1, 1'b0, 1'b0, 1'b1);        // R5 RSC with C=1
    drive(4'b0101, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1); // R3 ADC wrap, carry
    drive(4'b0011, 32'h1, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1);         // R4 RSB negative
    // sweep every opcode over corner operands
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          drive(4'(op), corners[i], corners[j], 1'((i + j) & 1), 1'(i & 1),
                1'(j & 1), 1'((op + i) & 1));
    // seeded pseudo-random operands
    for (int k = 0; k < 2000; k++) begin
      logic [W-1:0] a, b;
      logic [3:0] r;
      a = $urandom(); b = $urandom(); r = 4'($urandom());
      drive(4'(k % 16), a, b, r[0], r[1], r[2], r[3]);
    end
    @(negedge clk);
    wait (q.size() == 0);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule